// File: doc/BRIEF.md
# Endpoint Buffer Command Port

This block is the microcontroller-facing side of a USB device controller. A local processor reaches per-endpoint packet buffers through one parallel bus. A pin chooses whether that bus carries 8 or 16 bits per access. Every exchange opens with a command-phase write whose code names an endpoint and an operation. Data-phase accesses follow, marked by a separate command/data select input.

For a buffer operation, the data phase first carries the packet length, least significant byte first, and then the packet bytes. All of these pass through one shared synchronous RAM. That RAM holds two buffers of `BUF_BYTES` for every endpoint. For a status operation, the data phase returns one status byte, and that read acknowledges the endpoint's interrupt flag.

The serial engine is not part of this block. It appears only as strobes that do the following:
- fill RAM bytes;
- mark a buffer valid with a length;
- clear a buffer;
- report a SETUP token;
- set or clear stall.

Endpoints named in `DBL_MASK` move on to their second buffer when a DMA-style burst runs off the end of the first one.

Top module: `ep_cmd_port`

## Requirements
- R1: A command write decodes `hst_wdata[7:0]` only. Codes 00h..1Fh open the buffer of endpoint `code[3:0]`, and the direction is taken from each strobe. Codes 50h..5Fh open the status of endpoint `code[3:0]`. Any other code opens nothing: data reads then return 0 and data writes change no stored state.
- R2: On the 8-bit bus (`wide_bus`=0), a buffer data phase runs in this order: length low byte, length high byte, then packet bytes 0,1,2,... at `hst_rdata[7:0]` / `hst_wdata[7:0]`. The upper read byte is 0.
- R3: On the 16-bit bus, the command's upper byte is ignored. The first data word is the whole length. Each later word carries packet byte 2k in bits [7:0] and byte 2k+1 in bits [15:8], so an N-byte packet takes (N+1)/2 words.
- R4: A length read returns 0 while the selected buffer is not marked full. The stored length is returned only after `usb_done` for that buffer, or after a host length write, has set its full flag.
- R5: A status read returns exactly one byte and then the port opens nothing further. Bit 0 is full of buffer 0, bit 1 is full of buffer 1, bit 2 is stall and bit 3 is setup-received. Bits 7:4 are 0.
- R6: A status read clears that endpoint's `irq` bit and its setup flag. If `usb_done` or `usb_setup` for the same endpoint arrives in that same cycle, the flag stays set.
- R7: `stall_set` and `stall_clr` set and clear the stall flag. `usb_setup` sets the setup flag and the interrupt and clears stall, and it takes priority over a coincident `stall_set`. The bus cannot write any status bit.
- R8: Any command write abandons an unfinished data phase. The next data access starts again at the length field, in buffer 0, at byte 0.
- R9: Buffer accesses are not bounds-checked. Outside a DMA buffer switch, the byte pointer wraps modulo `BUF_BYTES` within the current buffer, so byte `BUF_BYTES` lands on byte 0.
- R10: With `dma_mode`=1 and the endpoint's `DBL_MASK` bit set, the access that finishes the last byte of buffer 0 moves the pointer to byte 0 of buffer 1. Otherwise R9 applies.
- R11: Data for a read strobe appears on `hst_rdata` in the cycle after the strobe. It holds until the next data read.
- R12: `usb_done` stores `usb_len` for (`usb_ep`,`usb_buf`), sets that buffer's full flag and raises `irq[usb_ep]`. `usb_clr` clears the full flag, and `usb_wr` stores `usb_byte` at `usb_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_bus | input | 1 | 1 selects 16-bit data phases, 0 selects 8-bit |
| dma_mode | input | 1 | Enables the buffer switch on double-buffered endpoints |
| hst_wr | input | 1 | Bus write strobe |
| hst_rd | input | 1 | Bus read strobe |
| hst_cmd | input | 1 | 1 marks a command phase, 0 a data phase |
| hst_wdata | input | 16 | Bus write data |
| hst_rdata | output | 16 | Bus read data, valid one cycle after the strobe |
| usb_wr | input | 1 | Engine writes one byte into a buffer |
| usb_ep | input | EPW (4) | Endpoint addressed by the engine strobes |
| usb_buf | input | 1 | Buffer addressed by the engine strobes |
| usb_addr | input | PW (6) | Byte address for `usb_wr` |
| usb_byte | input | 8 | Byte for `usb_wr` |
| usb_done | input | 1 | Successful transaction: store length, mark full, raise irq |
| usb_len | input | LW (7) | Length stored by `usb_done` |
| usb_clr | input | 1 | Clears the buffer's full flag |
| usb_setup | input | 1 | SETUP token received on `usb_ep` |
| stall_set | input | 1 | Stalls `usb_ep` |
| stall_clr | input | 1 | Unstalls `usb_ep` |
| irq | output | N_EP (16) | Per-endpoint interrupt flags |

## Verification
An interrupt can be set and acknowledged in the same cycle. The bench provokes this by driving `usb_done` for endpoint 3 in the very cycle that the status byte of endpoint 3 is read. It then expects the status byte as it stood before the event, and `irq[3]` still high afterwards. A second collision pairs `usb_setup` with `stall_set` on one endpoint. The next status read must show setup-received with stall clear.

// File: rtl/ep_cmd_pkg.sv
`timescale 1ns/1ps
package ep_cmd_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LEN0,
      PH_LEN1,
      PH_DATA,
      PH_STAT
   } phase_e;

   // status byte bit positions
   localparam int ST_FULL0 = 0;
   localparam int ST_FULL1 = 1;
   localparam int ST_STALL = 2;
   localparam int ST_SETUP = 3;

   // command code groups (upper bits of the command byte)
   localparam logic [2:0] OP_BUF_TOP  = 3'b000;
   localparam logic [3:0] OP_STAT_TOP = 4'h5;
endpackage

// File: rtl/ep_cmd_ram.sv
`timescale 1ns/1ps
module ep_cmd_ram #(
   parameter int N_EP      = 16,
   parameter int BUF_BYTES = 64,
   localparam int ROWS     = N_EP * BUF_BYTES,
   localparam int ROWW     = $clog2(ROWS)
) (
   input  logic            clk,
   input  logic [1:0]      h_we,
   input  logic            h_re,
   input  logic [ROWW-1:0] h_row,
   input  logic [15:0]     h_wd,
   output logic [1:0][7:0] h_q,
   input  logic            u_we,
   input  logic            u_bank,
   input  logic [ROWW-1:0] u_row,
   input  logic [7:0]      u_wd
);
   // two byte banks: even byte addresses in bank 0, odd in bank 1
   for (genvar g = 0; g < 2; g++) begin : g_bank
      logic [7:0] mem [ROWS];
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (u_we && (u_bank == 1'(g)))
            mem[u_row] <= u_wd;
         if (h_we[g])
            mem[h_row] <= h_wd[8*g +: 8];
         if (h_re)
            q <= mem[h_row];
      end
      assign h_q[g] = q;
   end
endmodule

// File: rtl/ep_cmd_flags.sv
`timescale 1ns/1ps
module ep_cmd_flags #(
   parameter int N_EP = 16,
   parameter int LW   = 7,
   localparam int EPW = $clog2(N_EP)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [EPW-1:0]                usb_ep,
   input  logic                          usb_buf,
   input  logic                          usb_done,
   input  logic [LW-1:0]                 usb_len,
   input  logic                          usb_clr,
   input  logic                          usb_setup,
   input  logic                          stall_set,
   input  logic                          stall_clr,
   input  logic [EPW-1:0]                h_ep,
   input  logic                          h_buf,
   input  logic                          h_len_we,
   input  logic [LW-1:0]                 h_len,
   input  logic                          h_stat_rd,
   output logic [N_EP-1:0][1:0]          full,
   output logic [N_EP-1:0][1:0][LW-1:0]  len,
   output logic [N_EP-1:0]               stall,
   output logic [N_EP-1:0]               setup,
   output logic [N_EP-1:0]               irq
);
   for (genvar e = 0; e < N_EP; e++) begin : g_ep
      logic hit_u, hit_h;
      logic stall_q, setup_q, irq_q;
      assign hit_u = (usb_ep == EPW'(e));
      assign hit_h = (h_ep == EPW'(e));

      for (genvar b = 0; b < 2; b++) begin : g_buf
         logic          sel_u, sel_h, full_q;
         logic [LW-1:0] len_q;
         assign sel_u = hit_u && (usb_buf == 1'(b));
         assign sel_h = hit_h && (h_buf == 1'(b));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               full_q <= 1'b0;
               len_q  <= '0;
            end else begin
               if (sel_u && usb_clr)  full_q <= 1'b0;
               if (sel_u && usb_done) begin
                  full_q <= 1'b1;
                  len_q  <= usb_len;
               end
               if (sel_h && h_len_we) begin
                  full_q <= 1'b1;
                  len_q  <= h_len;
               end
            end
         end
         assign full[e][b] = full_q;
         assign len[e][b]  = len_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stall_q <= 1'b0;
            setup_q <= 1'b0;
            irq_q   <= 1'b0;
         end else begin
            if (hit_u && usb_setup)     stall_q <= 1'b0;
            else if (hit_u && stall_set) stall_q <= 1'b1;
            else if (hit_u && stall_clr) stall_q <= 1'b0;

            if (hit_u && usb_setup)      setup_q <= 1'b1;
            else if (hit_h && h_stat_rd) setup_q <= 1'b0;

            if (hit_u && (usb_done || usb_setup)) irq_q <= 1'b1;
            else if (hit_h && h_stat_rd)          irq_q <= 1'b0;
         end
      end
      assign stall[e] = stall_q;
      assign setup[e] = setup_q;
      assign irq[e]   = irq_q;
   end
endmodule

// File: rtl/ep_cmd_port.sv
`timescale 1ns/1ps
module ep_cmd_port
   import ep_cmd_pkg::*;
#(
   parameter int          N_EP      = 16,
   parameter int          BUF_BYTES = 64,
   parameter logic [15:0] DBL_MASK  = 16'h00F0,
   localparam int EPW  = $clog2(N_EP),
   localparam int PW   = $clog2(BUF_BYTES),
   localparam int LW   = $clog2(BUF_BYTES + 1),
   localparam int ROWW = EPW + PW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wide_bus,
   input  logic            dma_mode,
   input  logic            hst_wr,
   input  logic            hst_rd,
   input  logic            hst_cmd,
   input  logic [15:0]     hst_wdata,
   output logic [15:0]     hst_rdata,
   input  logic            usb_wr,
   input  logic [EPW-1:0]  usb_ep,
   input  logic            usb_buf,
   input  logic [PW-1:0]   usb_addr,
   input  logic [7:0]      usb_byte,
   input  logic            usb_done,
   input  logic [LW-1:0]   usb_len,
   input  logic            usb_clr,
   input  logic            usb_setup,
   input  logic            stall_set,
   input  logic            stall_clr,
   output logic [N_EP-1:0] irq
);
   // elaboration-time parameter checks
   if (BUF_BYTES < 4 || BUF_BYTES > 64 || (1 << PW) != BUF_BYTES) begin : g_bad_buf
      $error("BUF_BYTES must be a power of two in 4..64");
   end
   if (N_EP < 2 || N_EP > 16 || (1 << EPW) != N_EP) begin : g_bad_ep
      $error("N_EP must be a power of two in 2..16");
   end

   phase_e          ph;
   logic [EPW-1:0]  cur_ep;
   logic            cur_buf;
   logic [PW:0]     ptr;
   logic [7:0]      len_lo_q;

   logic            data_acc, data_wr, data_rd, cmd_wr, stat_rd;
   logic [PW:0]     step, nxt_ptr;
   logic            dbl_wrap;
   logic            len_we;
   logic [LW-1:0]   len_wv;
   logic [15:0]     len_join;
   logic [15:0]     cur_len16;
   logic [7:0]      stat_byte;
   logic [1:0]      ram_we;
   logic [15:0]     ram_wd;
   logic            ram_re;
   logic [ROWW-1:0] h_row, u_row;
   logic [1:0][7:0] bank_q;

   logic            r_is_data, r_wide, r_odd;
   logic [15:0]     r_val;

   logic [N_EP-1:0][1:0]         flg_full;
   logic [N_EP-1:0][1:0][LW-1:0] flg_len;
   logic [N_EP-1:0]              flg_stall, flg_setup;

   always_comb begin
      cmd_wr   = hst_wr & hst_cmd;
      data_wr  = hst_wr & ~hst_cmd;
      data_rd  = hst_rd & ~hst_cmd;
      data_acc = data_wr | data_rd;
      stat_rd  = data_rd & (ph == PH_STAT);
      step     = wide_bus ? (PW+1)'(2) : (PW+1)'(1);
      nxt_ptr  = ptr + step;
      dbl_wrap = dma_mode & DBL_MASK[cur_ep] & ~cur_buf
                 & (nxt_ptr == (PW+1)'(BUF_BYTES));
      cur_len16 = flg_full[cur_ep][cur_buf] ? 16'(flg_len[cur_ep][cur_buf]) : 16'h0000;

      stat_byte           = 8'h00;
      stat_byte[ST_FULL0] = flg_full[cur_ep][0];
      stat_byte[ST_FULL1] = flg_full[cur_ep][1];
      stat_byte[ST_STALL] = flg_stall[cur_ep];
      stat_byte[ST_SETUP] = flg_setup[cur_ep];

      len_join = {hst_wdata[7:0], len_lo_q};
      len_we   = 1'b0;
      len_wv   = '0;
      if (data_wr && ph == PH_LEN0 && wide_bus) begin
         len_we = 1'b1;
         len_wv = hst_wdata[LW-1:0];
      end else if (data_wr && ph == PH_LEN1) begin
         len_we = 1'b1;
         len_wv = len_join[LW-1:0];
      end

      h_row  = {cur_ep, cur_buf, ptr[PW-1:1]};
      u_row  = {usb_ep, usb_buf, usb_addr[PW-1:1]};
      ram_re = data_rd & (ph == PH_DATA);
      ram_wd = wide_bus ? hst_wdata : {hst_wdata[7:0], hst_wdata[7:0]};
      ram_we = 2'b00;
      if (data_wr && ph == PH_DATA)
         ram_we = wide_bus ? 2'b11 : (ptr[0] ? 2'b10 : 2'b01);
   end

   // phase sequencer and byte pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         cur_ep   <= '0;
         cur_buf  <= 1'b0;
         ptr      <= '0;
         len_lo_q <= 8'h00;
      end else if (cmd_wr) begin
         cur_ep  <= hst_wdata[EPW-1:0];
         cur_buf <= 1'b0;
         ptr     <= '0;
         if (hst_wdata[7:5] == OP_BUF_TOP)       ph <= PH_LEN0;
         else if (hst_wdata[7:4] == OP_STAT_TOP) ph <= PH_STAT;
         else                                    ph <= PH_IDLE;
      end else if (data_acc) begin
         unique case (ph)
            PH_LEN0: begin
               if (data_wr) len_lo_q <= hst_wdata[7:0];
               ph <= wide_bus ? PH_DATA : PH_LEN1;
            end
            PH_LEN1: ph <= PH_DATA;
            PH_DATA: begin
               if (dbl_wrap) begin
                  cur_buf <= 1'b1;
                  ptr     <= '0;
               end else begin
                  ptr <= nxt_ptr;
               end
            end
            PH_STAT: ph <= PH_IDLE;
            default: ph <= PH_IDLE;
         endcase
      end
   end

   // read-data capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_is_data <= 1'b0;
         r_wide    <= 1'b0;
         r_odd     <= 1'b0;
         r_val     <= 16'h0000;
      end else if (data_rd) begin
         r_is_data <= (ph == PH_DATA);
         r_wide    <= wide_bus;
         r_odd     <= ptr[0];
         unique case (ph)
            PH_LEN0: r_val <= wide_bus ? cur_len16 : {8'h00, cur_len16[7:0]};
            PH_LEN1: r_val <= {8'h00, cur_len16[15:8]};
            PH_STAT: r_val <= {8'h00, stat_byte};
            default: r_val <= 16'h0000;
         endcase
      end
   end

   assign hst_rdata = !r_is_data ? r_val :
                      r_wide     ? {bank_q[1], bank_q[0]} :
                                   {8'h00, (r_odd ? bank_q[1] : bank_q[0])};

   ep_cmd_ram #(.N_EP(N_EP), .BUF_BYTES(BUF_BYTES)) u_ram (
      .clk    (clk),
      .h_we   (ram_we),
      .h_re   (ram_re),
      .h_row  (h_row),
      .h_wd   (ram_wd),
      .h_q    (bank_q),
      .u_we   (usb_wr),
      .u_bank (usb_addr[0]),
      .u_row  (u_row),
      .u_wd   (usb_byte)
   );

   ep_cmd_flags #(.N_EP(N_EP), .LW(LW)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .usb_ep    (usb_ep),
      .usb_buf   (usb_buf),
      .usb_done  (usb_done),
      .usb_len   (usb_len),
      .usb_clr   (usb_clr),
      .usb_setup (usb_setup),
      .stall_set (stall_set),
      .stall_clr (stall_clr),
      .h_ep      (cur_ep),
      .h_buf     (cur_buf),
      .h_len_we  (len_we),
      .h_len     (len_wv),
      .h_stat_rd (stat_rd),
      .full      (flg_full),
      .len       (flg_len),
      .stall     (flg_stall),
      .setup     (flg_setup),
      .irq       (irq)
   );
endmodule

// File: rtl/ep_cmd_port_chk.sv
`timescale 1ns/1ps
module ep_cmd_port_chk #(
   parameter int N_EP = 16,
   parameter int PW   = 6,
   localparam int EPW = $clog2(N_EP)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            hst_wr,
   input logic            hst_rd,
   input logic            hst_cmd,
   input logic [15:0]     hst_rdata,
   input logic            dma_mode,
   input logic            usb_done,
   input logic            usb_setup,
   input logic [EPW-1:0]  usb_ep,
   input logic [N_EP-1:0] irq,
   input logic            stat_rd,
   input logic [EPW-1:0]  cur_ep,
   input logic            cur_buf,
   input logic [PW:0]     ptr,
   input logic [N_EP-1:0] flg_stall
);
   p_done_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
      usb_done |=> irq[$past(usb_ep)]);

   p_stat_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !usb_done && !usb_setup) |=> !irq[$past(cur_ep)]);

   p_setup_unstall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      usb_setup |=> !flg_stall[$past(usb_ep)]);

   p_cmd_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_wr && hst_cmd) |=> (ptr == '0 && !cur_buf));

   p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(hst_rd && !hst_cmd) |=> $stable(hst_rdata));

   p_dma_switch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cur_buf) |-> $past(dma_mode));
endmodule

bind ep_cmd_port ep_cmd_port_chk #(.N_EP(N_EP), .PW(PW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hst_wr    (hst_wr),
   .hst_rd    (hst_rd),
   .hst_cmd   (hst_cmd),
   .hst_rdata (hst_rdata),
   .dma_mode  (dma_mode),
   .usb_done  (usb_done),
   .usb_setup (usb_setup),
   .usb_ep    (usb_ep),
   .irq       (irq),
   .stat_rd   (stat_rd),
   .cur_ep    (cur_ep),
   .cur_buf   (cur_buf),
   .ptr       (ptr),
   .flg_stall (flg_stall)
);

// File: tb/ep_cmd_port_tb.sv
`timescale 1ns/1ps
module ep_cmd_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_bus = 1'b0, dma_mode = 1'b0;
   logic        hst_wr = 1'b0, hst_rd = 1'b0, hst_cmd = 1'b0;
   logic [15:0] hst_wdata = 16'h0;
   logic [15:0] hst_rdata;
   logic        usb_wr = 1'b0, usb_buf = 1'b0, usb_done = 1'b0, usb_clr = 1'b0;
   logic        usb_setup = 1'b0, stall_set = 1'b0, stall_clr = 1'b0;
   logic [3:0]  usb_ep = 4'h0;
   logic [5:0]  usb_addr = 6'h0;
   logic [7:0]  usb_byte = 8'h0;
   logic [6:0]  usb_len = 7'h0;
   logic [15:0] irq;

   always #4 clk = ~clk;

   ep_cmd_port u_dut (.*);

   // reference model state, built from the requirements
   logic [7:0] mm [2048];
   bit         mk [2048];
   int         m_len [32];
   bit         m_full [32];
   bit         m_stall [16], m_setup [16], m_irq [16];
   int         m_ep, m_buf, m_ptr, m_ph, m_lo;
   int         n_cmp = 0, n_bad = 0;
   bit         done_flag = 1'b0;

   function automatic int aof(int p);
      return m_ep * 128 + m_buf * 64 + (p % 64);
   endfunction
   function automatic bit dbl(int e);
      return (16'h00F0 >> e) & 1;
   endfunction
   function automatic int stat_of(int e);
      return (int'(m_setup[e]) << 3) | (int'(m_stall[e]) << 2)
           | (int'(m_full[e*2+1]) << 1) | int'(m_full[e*2]);
   endfunction
   function automatic logic [15:0] irq_of();
      logic [15:0] v;
      for (int i = 0; i < 16; i++) v[i] = m_irq[i];
      return v;
   endfunction

   task automatic chk(string req, int act, int exp, int mask = 32'hFFFF);
      n_cmp++;
      if (((act ^ exp) & mask) != 0) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (mask %h)", req, act, exp, mask);
      end
   endtask

   task automatic adv(int s);
      int np;
      np = m_ptr + s;
      if (dma_mode && dbl(m_ep) && m_buf == 0 && np == 64) begin
         m_buf = 1; m_ptr = 0;
      end else m_ptr = np % 128;
   endtask

   task automatic cmd(int code);
      @(negedge clk);
      hst_wr = 1'b1; hst_cmd = 1'b1; hst_wdata = 16'(code) | 16'hA500;
      @(negedge clk);
      hst_wr = 1'b0; hst_cmd = 1'b0;
      m_ptr = 0; m_buf = 0; m_ep = code & 15;
      m_ph = ((code >> 5) == 0) ? 1 : (((code >> 4) & 15) == 5) ? 4 : 0;
   endtask

   task automatic dwr(int v);
      int li;
      @(negedge clk);
      hst_wr = 1'b1; hst_wdata = 16'(v);
      @(negedge clk);
      hst_wr = 1'b0;
      li = m_ep * 2 + m_buf;
      case (m_ph)
         1: if (wide_bus) begin
               m_len[li] = v & 127; m_full[li] = 1; m_ph = 3;
            end else begin
               m_lo = v & 255; m_ph = 2;
            end
         2: begin m_len[li] = (((v & 255) << 8) | m_lo) & 127; m_full[li] = 1; m_ph = 3; end
         3: if (wide_bus) begin
               mm[aof(m_ptr)] = 8'(v); mk[aof(m_ptr)] = 1;
               mm[aof(m_ptr+1)] = 8'(v >> 8); mk[aof(m_ptr+1)] = 1;
               adv(2);
            end else begin
               mm[aof(m_ptr)] = 8'(v); mk[aof(m_ptr)] = 1; adv(1);
            end
         4: m_ph = 0;
         default: ;
      endcase
   endtask

   task automatic drd(string req);
      int exp, msk, ln, li;
      exp = 0; msk = 32'hFFFF;
      li = m_ep * 2 + m_buf;
      ln = m_full[li] ? m_len[li] : 0;
      case (m_ph)
         1: begin exp = wide_bus ? ln : (ln & 255); m_ph = wide_bus ? 3 : 2; end
         2: begin exp = (ln >> 8) & 255; m_ph = 3; end
         3: if (wide_bus) begin
               exp = (int'(mm[aof(m_ptr+1)]) << 8) | int'(mm[aof(m_ptr)]);
               msk = (mk[aof(m_ptr+1)] ? 32'hFF00 : 0) | (mk[aof(m_ptr)] ? 32'h00FF : 0);
               adv(2);
            end else begin
               exp = int'(mm[aof(m_ptr)]);
               msk = 32'hFF00 | (mk[aof(m_ptr)] ? 32'h00FF : 0);
               adv(1);
            end
         4: begin exp = stat_of(m_ep); m_irq[m_ep] = 0; m_setup[m_ep] = 0; m_ph = 0; end
         default: exp = 0;
      endcase
      @(negedge clk);
      hst_rd = 1'b1; hst_cmd = 1'b0;
      @(negedge clk);
      hst_rd = 1'b0;
      chk(req, int'(hst_rdata), exp, msk);
   endtask

   task automatic u_fill(int e, int b, int a, int v);
      @(negedge clk);
      usb_wr = 1'b1; usb_ep = 4'(e); usb_buf = 1'(b); usb_addr = 6'(a); usb_byte = 8'(v);
      @(negedge clk);
      usb_wr = 1'b0;
      mm[e*128 + b*64 + a] = 8'(v); mk[e*128 + b*64 + a] = 1;
   endtask

   task automatic u_done(int e, int b, int n);
      @(negedge clk);
      usb_done = 1'b1; usb_ep = 4'(e); usb_buf = 1'(b); usb_len = 7'(n);
      @(negedge clk);
      usb_done = 1'b0;
      m_len[e*2+b] = n; m_full[e*2+b] = 1; m_irq[e] = 1;
   endtask

   task automatic u_clr(int e, int b);
      @(negedge clk);
      usb_clr = 1'b1; usb_ep = 4'(e); usb_buf = 1'(b);
      @(negedge clk);
      usb_clr = 1'b0;
      m_full[e*2+b] = 0;
   endtask

   task automatic host_pkt(int e, int n, int w);
      wide_bus = 1'(w);
      cmd(e & 15);
      if (w) dwr(n);
      else begin dwr(n & 255); dwr(n >> 8); end
      if (w) for (int k = 0; k < (n + 1) / 2; k++) dwr($urandom_range(0, 65535));
      else   for (int k = 0; k < n; k++) dwr($urandom_range(0, 255));
   endtask

   task automatic read_back(int e, int n, int w);
      wide_bus = 1'(w);
      cmd(16 | e);
      drd(w ? "R3 length word" : "R2 length low");
      if (!w) drd("R2 length high");
      if (w) for (int k = 0; k < (n + 1) / 2; k++) drd("R3 data word");
      else   for (int k = 0; k < n; k++) drd("R2 data byte");
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] hold;
      void'($urandom(32'd20011));
      for (int i = 0; i < 2048; i++) begin mm[i] = 8'h0; mk[i] = 0; end
      for (int i = 0; i < 32; i++) begin m_len[i] = 0; m_full[i] = 0; end
      for (int i = 0; i < 16; i++) begin m_stall[i] = 0; m_setup[i] = 0; m_irq[i] = 0; end
      m_ep = 0; m_buf = 0; m_ptr = 0; m_ph = 0; m_lo = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 reset irq", int'(irq), 0);
      chk("R11 reset rdata", int'(hst_rdata), 0);

      // R1: unknown code opens nothing
      cmd(8'h30);
      drd("R1 idle read");
      dwr(16'h0077);
      cmd(8'h10 | 1);
      drd("R1 no length stored");

      // R4/R12: OUT-style buffer invisible until usb_done
      u_fill(6, 0, 0, 8'h3C);
      u_fill(6, 0, 1, 8'hC3);
      cmd(8'h16);
      drd("R4 length before done");
      u_done(6, 0, 2);
      chk("R12 irq after done", int'(irq), int'(irq_of()));
      read_back(6, 2, 0);

      // R5/R6: status read then interrupt acknowledged
      cmd(8'h56);
      drd("R5 status byte");
      chk("R6 irq cleared", int'(irq), int'(irq_of()));
      drd("R5 one byte only");

      // R6: set and clear collide
      cmd(8'h53);
      @(negedge clk);
      hst_rd = 1'b1; usb_done = 1'b1; usb_ep = 4'd3; usb_buf = 1'b0; usb_len = 7'd5;
      @(negedge clk);
      hst_rd = 1'b0; usb_done = 1'b0;
      chk("R6 status before collision", int'(hst_rdata), stat_of(3));
      m_len[6] = 5; m_full[6] = 1; m_irq[3] = 1; m_ph = 0;
      chk("R6 irq survives collision", int'(irq[3]), 1);

      // R7: stall, then setup colliding with stall_set
      @(negedge clk); stall_set = 1'b1; usb_ep = 4'd4;
      @(negedge clk); stall_set = 1'b0; m_stall[4] = 1;
      cmd(8'h54);
      drd("R7 stall visible");
      @(negedge clk); usb_setup = 1'b1; stall_set = 1'b1; usb_ep = 4'd4;
      @(negedge clk); usb_setup = 1'b0; stall_set = 1'b0;
      m_stall[4] = 0; m_setup[4] = 1; m_irq[4] = 1;
      chk("R7 setup irq", int'(irq), int'(irq_of()));
      cmd(8'h54);
      dwr(16'h00FF);
      cmd(8'h54);
      drd("R7 setup wins, bus write ignored");
      @(negedge clk); stall_set = 1'b1; usb_ep = 4'd4;
      @(negedge clk); stall_set = 1'b0; stall_clr = 1'b1;
      @(negedge clk); stall_clr = 1'b0;
      cmd(8'h54);
      drd("R7 stall cleared");

      // R8: new command restarts the data phase
      wide_bus = 1'b0;
      cmd(8'h02); dwr(3); dwr(0); dwr(8'hAA); dwr(8'hBB);
      cmd(8'h02); dwr(2); dwr(0); dwr(8'h11);
      cmd(8'h12);
      drd("R8 length after abort");
      drd("R8 length high");
      drd("R8 byte0 rewritten");
      drd("R8 byte1 kept");

      // R11: read data holds
      hold = hst_rdata;
      repeat (4) @(negedge clk);
      chk("R11 hold", int'(hst_rdata), int'(hold));

      // R9: wrap on a single-buffered endpoint
      host_pkt(9, 65, 0);
      read_back(9, 65, 0);

      // R10: DMA switch on a double-buffered endpoint, 8-bit and 16-bit
      dma_mode = 1'b1;
      host_pkt(5, 66, 0);
      read_back(5, 66, 0);
      host_pkt(7, 68, 1);
      read_back(7, 68, 1);
      host_pkt(10, 66, 0);
      read_back(10, 66, 0);
      dma_mode = 1'b0;

      // R3: 16-bit odd length, mixed widths
      host_pkt(11, 7, 1);
      read_back(11, 7, 1);
      read_back(11, 7, 0);

      // random traffic
      for (int it = 0; it < 40; it++) begin
         int e, n, w;
         e = $urandom_range(0, 15);
         n = $urandom_range(1, 64);
         w = $urandom_range(0, 1);
         if (it % 2 == 0) host_pkt(e, n, w);
         else begin
            u_clr(e, 0);
            for (int k = 0; k < n; k++) u_fill(e, 0, k, $urandom_range(0, 255));
            wide_bus = 1'(w);
            cmd(16 | e);
            drd("R4 random not full");
            u_done(e, 0, n);
         end
         read_back(e, n, $urandom_range(0, 1));
         cmd(8'h50 | e);
         drd("R5 random status");
         chk("R6 random irq", int'(irq), int'(irq_of()));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule